// File: doc/BRIEF.md
# CPU Wait-State Generator with Watchdog Release

This block holds a processor in a wait state so that byte-by-byte disk transfers stay in step with the disk controller. Software starts a wait by writing the drive-control register with its wait bit set. From then on the active-low `wait_n` output stays low and keeps the processor stalled. The stall ends when the controller raises its data request, when it raises its interrupt request, when reset is applied, or when a built-in watchdog finds that the wait has lasted too long.

The watchdog exists so that a controller fault can never stall the bus long enough for dynamic memory to lose its contents. It counts clock cycles from the most recent accepted arming write. A sticky flag records that the watchdog, and not the controller, ended a wait. Software can read this flag to tell a fault from a normal transfer.

The request inputs come from the controller's own timing domain and pass through a synchronizer. Its depth is a parameter and may be zero. The arming strobe is already in the block's clock domain.

Top module: `cpu_wait_gen`

## Requirements
- R1: While `rst_n` is low, `wait_n` is 1 and `wdog_timeout` is 0. Asserting `rst_n` during a wait ends the wait at once, without waiting for a clock edge.
- R2: A clock edge that samples `sel_wr`=1 and `sel_wait_bit`=1, with no release condition present, drives `wait_n` to 0 after that edge.
- R3: A clock edge that samples `sel_wr`=1 and `sel_wait_bit`=0 does not start a wait. It also does not end a wait that is already running.
- R4: While a wait runs, `drq`=1 ends it. `wait_n` returns to 1 on the (SYNC_STAGES+1)-th rising edge that samples `drq` high.
- R5: While a wait runs, `intrq`=1 ends it, with the same latency as `drq` in R4.
- R6: With no other release condition, a wait lasts exactly WDOG_LIMIT clock cycles. `wdog_timeout` rises on the same edge at which `wait_n` returns to 1.
- R7: `wdog_timeout` stays 1 until reset, or until the next edge that samples an arming write (`sel_wr`=1, `sel_wait_bit`=1). A write with `sel_wait_bit`=0 leaves the flag unchanged.
- R8: If a release condition is present on the same edge as an arming write, the release wins and `wait_n` stays 1.
- R9: An arming write accepted during a wait restarts the watchdog. The wait then lasts WDOG_LIMIT cycles counted from that write.
- R10: `wait_n` falls only on an edge that samples an arming write. With no such write, it stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; also a release condition |
| sel_wr | input | 1 | One-cycle strobe for a write to the drive-control register |
| sel_wait_bit | input | 1 | Wait bit of that write; 1 arms a wait |
| drq | input | 1 | Controller data request (asynchronous) |
| intrq | input | 1 | Controller interrupt request (asynchronous) |
| wait_n | output | 1 | Active-low processor wait, registered |
| wdog_timeout | output | 1 | Sticky flag: the watchdog ended the last wait |

## Verification
The assertions assume that `sel_wr` and `sel_wait_bit` are synchronous to `clk`. They judge the release inputs only after the synchronizer, so they make no assumption about when `drq` and `intrq` change. The bench drives every input on the falling edge and samples on the falling edge. It holds each request level for at least SYNC_STAGES+1 cycles and lets it drain for the same time before the next scenario, so every synchronized level is stable when a check reads it.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
   // Release requests arriving from the disk controller
   typedef struct packed {
      logic drq;
      logic intrq;
   } ctl_req_t;

   localparam int unsigned CTL_REQ_W = $bits(ctl_req_t);
endpackage

// File: rtl/cwg_sync.sv
module cwg_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stage_q[s] <= '0;
               end else if (s == 0) begin
                  stage_q[s] <= din;
               end else begin
                  stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
               end
            end
         end
         assign dout = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cwg_watchdog.sv
module cwg_watchdog #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic expire
);
   localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;

   assign expire = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !run) begin
         cnt_q <= '0;
      end else if (!expire) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cpu_wait_gen.sv
module cpu_wait_gen
   import cwg_pkg::*;
#(
   parameter int unsigned WDOG_LIMIT  = 1000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_wr,
   input  logic sel_wait_bit,
   input  logic drq,
   input  logic intrq,
   output logic wait_n,
   output logic wdog_timeout
);
   generate
      if (WDOG_LIMIT < 2) begin : g_bad_limit
         $error("WDOG_LIMIT must be at least 2");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
   endgenerate

   ctl_req_t req_raw, req_s;
   logic     drq_s, intrq_s;
   logic     arm, wd_expire, release_c;
   logic     waiting_q, tmo_q;

   assign req_raw.drq   = drq;
   assign req_raw.intrq = intrq;

   cwg_sync #(.WIDTH(CTL_REQ_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (req_raw),
      .dout (req_s)
   );

   assign drq_s   = req_s.drq;
   assign intrq_s = req_s.intrq;

   assign arm       = sel_wr && sel_wait_bit;
   assign release_c = drq_s || intrq_s || wd_expire;

   cwg_watchdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(arm),
      .run    (waiting_q),
      .expire (wd_expire)
   );

   // Release has priority over arming
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waiting_q <= 1'b0;
      end else if (release_c) begin
         waiting_q <= 1'b0;
      end else if (arm) begin
         waiting_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_q <= 1'b0;
      end else if (wd_expire) begin
         tmo_q <= 1'b1;
      end else if (arm) begin
         tmo_q <= 1'b0;
      end
   end

   assign wait_n       = ~waiting_q;
   assign wdog_timeout = tmo_q;
endmodule

// File: rtl/cwg_checker.sv
module cwg_checker #(
   parameter int unsigned WDOG_LIMIT = 1000
) (
   input logic clk,
   input logic rst_n,
   input logic sel_wr,
   input logic sel_wait_bit,
   input logic drq_s,
   input logic intrq_s,
   input logic wait_n,
   input logic wdog_timeout
);
   localparam int unsigned CW = $clog2(WDOG_LIMIT + 2) + 1;

   logic          arm_w, req_w;
   logic [CW-1:0] low_cnt;

   assign arm_w = sel_wr && sel_wait_bit;
   assign req_w = drq_s || intrq_s;

   // Independent count of cycles spent in wait since the last arming write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
      end else if (arm_w && !req_w) begin
         low_cnt <= CW'(1);
      end else if (!wait_n && low_cnt <= CW'(WDOG_LIMIT)) begin
         low_cnt <= low_cnt + 1'b1;
      end else if (wait_n) begin
         low_cnt <= '0;
      end
   end

   p_fall_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wait_n) |-> $past(arm_w));

   p_arm_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_w && !req_w && low_cnt < CW'(WDOG_LIMIT)) |=> !wait_n);

   p_drq_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wait_n && drq_s) |=> wait_n);

   p_intrq_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wait_n && intrq_s) |=> wait_n);

   p_release_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_n && arm_w && req_w) |=> wait_n);

   p_clear_write_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wait_n && sel_wr && !sel_wait_bit && !req_w && low_cnt < CW'(WDOG_LIMIT))
      |=> !wait_n);

   p_wdog_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wait_n |-> (low_cnt <= CW'(WDOG_LIMIT)));

   p_timeout_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdog_timeout) |-> $rose(wait_n));

   p_timeout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wdog_timeout && !arm_w) |=> wdog_timeout);
endmodule

bind cpu_wait_gen cwg_checker #(.WDOG_LIMIT(WDOG_LIMIT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sel_wr      (sel_wr),
   .sel_wait_bit(sel_wait_bit),
   .drq_s       (drq_s),
   .intrq_s     (intrq_s),
   .wait_n      (wait_n),
   .wdog_timeout(wdog_timeout)
);

// File: tb/cpu_wait_gen_test.sv
`timescale 1ns/1ps
module cpu_wait_gen_test;
   localparam int L = 1000;
   localparam int S = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_wr = 1'b0, sel_wait_bit = 1'b0, drq = 1'b0, intrq = 1'b0;
   logic wait_n, wdog_timeout;
   int   n_checks = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   cpu_wait_gen #(.WDOG_LIMIT(L), .SYNC_STAGES(S)) uut (
      .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wait_bit(sel_wait_bit),
      .drq(drq), .intrq(intrq), .wait_n(wait_n), .wdog_timeout(wdog_timeout)
   );

   task automatic chk(string tag, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic reg_write(logic b);
      @(negedge clk);
      sel_wr = 1'b1; sel_wait_bit = b;
      @(negedge clk);
      sel_wr = 1'b0; sel_wait_bit = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      idle(3);
      chk("R1 wait_n in reset", wait_n, 1'b1);
      chk("R1 timeout in reset", wdog_timeout, 1'b0);
      rst_n = 1'b1;
      idle(20);
      chk("R10 no wait without write", wait_n, 1'b1);
   endtask

   task automatic t_drq_release;
      reg_write(1'b1);
      chk("R2 wait after arming write", wait_n, 1'b0);
      idle(10);
      chk("R2 wait held", wait_n, 1'b0);
      drq = 1'b1;
      idle(S);
      chk("R4 still waiting before sync latency", wait_n, 1'b0);
      idle(1);
      chk("R4 released by drq", wait_n, 1'b1);
      chk("R6 no timeout on drq release", wdog_timeout, 1'b0);
      drq = 1'b0;
      idle(S + 2);
   endtask

   task automatic t_clear_bit;
      reg_write(1'b0);
      chk("R3 clear-bit write does not start", wait_n, 1'b1);
      reg_write(1'b1);
      idle(5);
      reg_write(1'b0);
      idle(3);
      chk("R3 clear-bit write does not end", wait_n, 1'b0);
      intrq = 1'b1;
      idle(S);
      chk("R5 still waiting before sync latency", wait_n, 1'b0);
      idle(1);
      chk("R5 released by intrq", wait_n, 1'b1);
      intrq = 1'b0;
      idle(S + 2);
   endtask

   task automatic t_watchdog;
      reg_write(1'b1);
      idle(L - 1);
      chk("R6 wait lasts full limit", wait_n, 1'b0);
      chk("R6 timeout not early", wdog_timeout, 1'b0);
      idle(1);
      chk("R6 watchdog release", wait_n, 1'b1);
      chk("R6 timeout flag set", wdog_timeout, 1'b1);
      idle(8);
      chk("R7 flag sticky", wdog_timeout, 1'b1);
      reg_write(1'b0);
      chk("R7 clear-bit write keeps flag", wdog_timeout, 1'b1);
      reg_write(1'b1);
      chk("R7 arming write clears flag", wdog_timeout, 1'b0);
      intrq = 1'b1;
      idle(S + 1);
      chk("R5 release after flag clear", wait_n, 1'b1);
      intrq = 1'b0;
      idle(S + 2);
   endtask

   task automatic t_release_wins;
      drq = 1'b1;
      idle(S + 2);
      reg_write(1'b1);
      chk("R8 release beats arm", wait_n, 1'b1);
      idle(3);
      chk("R8 still no wait", wait_n, 1'b1);
      drq = 1'b0;
      idle(S + 2);
      chk("R10 no wait after drq drops", wait_n, 1'b1);
   endtask

   task automatic t_rearm;
      reg_write(1'b1);
      idle(300);
      reg_write(1'b1);
      idle(L - 1);
      chk("R9 rearm restarts watchdog", wait_n, 1'b0);
      idle(1);
      chk("R9 release after restarted limit", wait_n, 1'b1);
      chk("R9 timeout after restart", wdog_timeout, 1'b1);
   endtask

   task automatic t_reset_mid_wait;
      reg_write(1'b1);
      chk("R2 wait before reset", wait_n, 1'b0);
      idle(4);
      #1 rst_n = 1'b0;
      #0.5;
      chk("R1 reset releases at once", wait_n, 1'b1);
      chk("R1 reset clears flag", wdog_timeout, 1'b0);
      idle(2);
      rst_n = 1'b1;
      idle(3);
   endtask

   initial begin
      t_reset();
      t_drq_release();
      t_clear_bit();
      t_watchdog();
      t_release_wins();
      t_rearm();
      t_reset_mid_wait();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule